// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the per-thread control engine of a register-rename pipeline stage. It tracks whether the thread is idle, running, blocked, unblocking, squashing or held for a serializing instruction. It signals block and unblock requests back to the decode stage. It holds instructions that arrive while the stage cannot accept them. It also passes renamed instructions forward one per cycle. Register lookup, the free list and resource accounting are outside the block. A single `stall_i` pin summarises every downstream or resource reason to stop.

Instructions arrive one per cycle as `in_valid_i` plus a sequence number and a serialize-before flag. The forward path is valid-only: the consumer applies back-pressure through `stall_i`, never by withholding a ready. The backward path is the `dec_block_o` / `dec_unblock_o` pulse pair. After a block pulse, decode may keep delivering for up to `BP_DELAY` cycles, and the skid store is sized so that this traffic never overflows it. Every output is registered, so a decision taken from the inputs sampled at one rising edge becomes visible after that edge.

Each cycle, the conditions are taken in a fixed order. A commit squash wins. A still-squashing reorder buffer comes next. A stall comes last. A thread parked on a serializing instruction stays parked until the reorder buffer is empty and no renamed instruction is still in flight.

Top module: `rn_stall_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the thread idle (`state_o` = 0) with an empty skid store and with `out_valid_o`, `dec_block_o` and `dec_unblock_o` all low.
- R2: The inputs are ranked `squash_i` > `rob_squashing_i` > `stall_i`. Either squash input moves the thread to squashing (`state_o` = 4), and a stall in the same cycle then raises no block pulse.
- R3: On a stall, `dec_block_o` pulses only if the thread was neither blocked (2) nor unblocking (3). The thread enters blocked, except that serialize-stall (5) is kept. An arrival during a stall is appended to the skid store.
- R4: When no condition applies, blocked goes to unblocking. Squashing goes to running (1) if the skid store is empty, and otherwise to unblocking.
- R5: While unblocking, one live entry leaves the skid store per cycle, oldest first, and arrivals are appended at its tail. When the store becomes empty outside serialize-stall, `dec_unblock_o` pulses and the thread runs.
- R6: A squash while blocked, unblocking or serialize-stalled pulses `dec_unblock_o`, and the held serializing instruction is discarded and never emitted.
- R7: A squash marks every stored entry whose sequence number is strictly greater than `squash_seq_i`, and drops such an arrival in that cycle. Marked entries are skipped in the same cycle as the next live entry, so they cost no output slot.
- R8: An instruction with `in_ser_i` = 1 is not emitted on arrival. The thread enters serialize-stall (5) and raises a block pulse if it was not blocked or unblocking. On release, the held instruction is emitted ahead of every stored entry.
- R9: The in-flight count rises by one for each emitted instruction and falls by one for each `dispatch_i` pulse. Serialize-stall is released only in a cycle where `rob_empty_i` is high and that count is zero.
- R10: The skid store holds 2 x `BP_DELAY` + 1 entries, and a push into a full store is a fatal condition.
- R11: In idle or running, a plain arrival is emitted on `out_valid_o` / `out_seq_o` after the next edge, and the thread is then running.
- R12: If a release from serialize-stall finds the skid store empty while a new instruction arrives, the held one is emitted, the arrival is stored, `dec_block_o` pulses and the thread is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Instruction arriving from decode |
| in_seq_i | input | 16 | Sequence number of the arrival |
| in_ser_i | input | 1 | Arrival must wait for an empty pipeline |
| out_valid_o | output | 1 | Instruction passed forward this cycle |
| out_seq_o | output | 16 | Sequence number passed forward |
| squash_i | input | 1 | Commit-side squash |
| squash_seq_i | input | 16 | Youngest surviving sequence number |
| rob_squashing_i | input | 1 | Reorder buffer still squashing |
| stall_i | input | 1 | Any downstream or resource stall |
| rob_empty_i | input | 1 | Reorder buffer holds nothing |
| dispatch_i | input | 1 | One renamed instruction left for dispatch |
| dec_block_o | output | 1 | Block request pulse toward decode |
| dec_unblock_o | output | 1 | Unblock request pulse toward decode |
| state_o | output | 3 | Thread state code |

## Verification
The bench targets squashed entries that lie between live ones. A design that spent a cycle on each marked entry would emit the later live instruction one cycle late. It also releases a serializing instruction with entries already stored. A design that appended the held instruction instead of placing it first would reorder the stream. A stall that arrives during serialize-stall must not move the thread to blocked, or the held instruction is lost. A squash that coincides with a stall must not produce a block pulse. Repeated stalls must pulse block only once, and a store filled to its full depth must drain every entry in order.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_SEQ_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4,
    ST_SER  = 3'd5
  } rn_state_e;

  typedef struct packed {
    logic [RN_SEQ_W-1:0] seq;
    logic                ser;
    logic                dead;
  } rn_ent_t;
endpackage

// File: rtl/rn_skid_buf.sv
module rn_skid_buf
  import rn_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 push_i,
  input  rn_ent_t              push_ent_i,
  input  logic [CNT_W-1:0]     pop_cnt_i,
  input  logic                 kill_i,
  input  logic [RN_SEQ_W-1:0]  kill_seq_i,
  output logic [CNT_W-1:0]     count_o,
  output rn_ent_t [DEPTH-1:0]  view_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W:0] DEP_X = (IDX_W + 1)'(DEPTH);

  function automatic logic [IDX_W-1:0] wrap(input logic [IDX_W:0] s);
    logic [IDX_W:0] t;
    t = (s >= DEP_X) ? s - DEP_X : s;
    return t[IDX_W-1:0];
  endfunction

  rn_ent_t          mem [DEPTH];
  logic [IDX_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] after_pop;
  logic [IDX_W-1:0] tail;
  logic             push_ok;

  assign after_pop = count - pop_cnt_i;
  assign push_ok   = push_i && (after_pop < CNT_W'(DEPTH));
  assign tail      = wrap({1'b0, head} + (IDX_W + 1)'(count));
  assign count_o   = count;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      view_o[i] = mem[wrap({1'b0, head} + (IDX_W + 1)'(i))];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      head  <= '0;
      count <= '0;
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        if (kill_i && (mem[j].seq > kill_seq_i)) mem[j].dead <= 1'b1;
      end
      if (push_ok) mem[tail] <= push_ent_i;
      head  <= wrap({1'b0, head} + (IDX_W + 1)'(pop_cnt_i));
      count <= after_pop + CNT_W'(push_ok);
    end
  end
endmodule

// File: rtl/rn_flight_ctr.sv
module rn_flight_ctr #(
  parameter int unsigned FL_W = 6
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o
);
  localparam logic [FL_W-1:0] FL_MAX = '1;
  logic [FL_W-1:0] cnt;

  assign zero_o = (cnt == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt <= '0;
    end else if (inc_i && !dec_i) begin
      if (cnt != FL_MAX) cnt <= cnt + 1'b1;
    end else if (dec_i && !inc_i) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rn_stall_fsm.sv
module rn_stall_fsm
  import rn_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                squash_i,
  input  logic [RN_SEQ_W-1:0] squash_seq_i,
  input  logic                rob_sq_i,
  input  logic                stall_i,
  input  logic                rob_empty_i,
  input  logic                fl_zero_i,
  input  logic                in_valid_i,
  input  logic [RN_SEQ_W-1:0] in_seq_i,
  input  logic                in_ser_i,
  input  logic [CNT_W-1:0]    sk_count_i,
  input  rn_ent_t [DEPTH-1:0] sk_view_i,
  output rn_state_e           state_o,
  output logic                emit_o,
  output logic [RN_SEQ_W-1:0] emit_seq_o,
  output logic                blk_o,
  output logic                ublk_o,
  output logic                push_o,
  output rn_ent_t             push_ent_o,
  output logic [CNT_W-1:0]    pop_cnt_o,
  output logic                kill_o
);
  rn_state_e           state, nstate;
  logic [RN_SEQ_W-1:0] held, held_n;
  logic                found;
  logic [CNT_W-1:0]    fidx;
  logic                drain, run;
  logic [CNT_W:0]      remain;

  assign state_o = state;

  // oldest entry not marked by a squash
  always_comb begin
    found = 1'b0;
    fidx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && (CNT_W'(i) < sk_count_i) && !sk_view_i[i].dead) begin
        found = 1'b1;
        fidx  = CNT_W'(i);
      end
    end
  end

  always_comb begin
    nstate     = state;
    held_n     = held;
    emit_o     = 1'b0;
    emit_seq_o = '0;
    blk_o      = 1'b0;
    ublk_o     = 1'b0;
    push_o     = 1'b0;
    push_ent_o = '{seq: in_seq_i, ser: in_ser_i, dead: 1'b0};
    pop_cnt_o  = '0;
    kill_o     = 1'b0;
    drain      = 1'b0;
    run        = 1'b0;
    remain     = '0;

    if (squash_i) begin
      if (state == ST_BLK || state == ST_UNB || state == ST_SER) ublk_o = 1'b1;
      kill_o = 1'b1;
      push_o = in_valid_i && !(in_seq_i > squash_seq_i);
      nstate = ST_SQ;
    end else if (rob_sq_i) begin
      push_o = in_valid_i;
      nstate = ST_SQ;
    end else if (stall_i) begin
      if (state != ST_BLK && state != ST_UNB) blk_o = 1'b1;
      if (state != ST_SER) nstate = ST_BLK;
      push_o = in_valid_i;
    end else begin
      case (state)
        ST_SER: begin
          if (rob_empty_i && fl_zero_i) begin
            emit_o     = 1'b1;
            emit_seq_o = held;
            if (sk_count_i != '0) begin
              nstate = ST_UNB;
              push_o = in_valid_i;
            end else if (in_valid_i) begin
              push_o = 1'b1;
              blk_o  = 1'b1;
              nstate = ST_BLK;
            end else begin
              nstate = ST_RUN;
            end
          end else begin
            push_o = in_valid_i;
          end
        end
        ST_BLK, ST_UNB: drain = 1'b1;
        ST_SQ: begin
          if (sk_count_i != '0) drain = 1'b1;
          else begin
            run    = 1'b1;
            nstate = ST_RUN;
          end
        end
        default: run = 1'b1;
      endcase
    end

    if (drain) begin
      push_o = in_valid_i;
      if (found) begin
        pop_cnt_o = fidx + CNT_W'(1);
        if (sk_view_i[fidx].ser) begin
          nstate = ST_SER;
          held_n = sk_view_i[fidx].seq;
        end else begin
          emit_o     = 1'b1;
          emit_seq_o = sk_view_i[fidx].seq;
        end
      end else begin
        pop_cnt_o = sk_count_i;
      end
      remain = {1'b0, sk_count_i} - {1'b0, pop_cnt_o} + (CNT_W + 1)'(in_valid_i);
      if (nstate != ST_SER) begin
        if (remain == '0) begin
          ublk_o = 1'b1;
          nstate = ST_RUN;
        end else begin
          nstate = ST_UNB;
        end
      end
    end

    if (run && in_valid_i) begin
      if (in_ser_i) begin
        nstate = ST_SER;
        held_n = in_seq_i;
        blk_o  = 1'b1;
      end else begin
        emit_o     = 1'b1;
        emit_seq_o = in_seq_i;
        nstate     = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state <= ST_IDLE;
      held  <= '0;
    end else begin
      state <= nstate;
      held  <= held_n;
    end
  end
endmodule

// File: rtl/rn_stall_ctrl.sv
module rn_stall_ctrl
  import rn_pkg::*;
#(
  parameter int unsigned BP_DELAY = 2,
  parameter int unsigned FL_W     = 6
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                in_valid_i,
  input  logic [RN_SEQ_W-1:0] in_seq_i,
  input  logic                in_ser_i,
  output logic                out_valid_o,
  output logic [RN_SEQ_W-1:0] out_seq_o,
  input  logic                squash_i,
  input  logic [RN_SEQ_W-1:0] squash_seq_i,
  input  logic                rob_squashing_i,
  input  logic                stall_i,
  input  logic                rob_empty_i,
  input  logic                dispatch_i,
  output logic                dec_block_o,
  output logic                dec_unblock_o,
  output logic [2:0]          state_o
);
  localparam int unsigned IN_LANES  = 1;
  localparam int unsigned OUT_LANES = 1;
  localparam int unsigned DEPTH     = 2 * BP_DELAY * IN_LANES + OUT_LANES;
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1);

  rn_state_e           st;
  logic                emit, blk, ublk;
  logic [RN_SEQ_W-1:0] emit_seq;
  logic                sk_push, sk_kill, fl_zero;
  rn_ent_t             sk_ent;
  logic [CNT_W-1:0]    sk_pop, sk_count;
  rn_ent_t [DEPTH-1:0] sk_view;

  rn_skid_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) skid_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .push_i     (sk_push),
    .push_ent_i (sk_ent),
    .pop_cnt_i  (sk_pop),
    .kill_i     (sk_kill),
    .kill_seq_i (squash_seq_i),
    .count_o    (sk_count),
    .view_o     (sk_view)
  );

  rn_flight_ctr #(.FL_W(FL_W)) flight_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .inc_i  (emit),
    .dec_i  (dispatch_i),
    .zero_o (fl_zero)
  );

  rn_stall_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) fsm_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .squash_i     (squash_i),
    .squash_seq_i (squash_seq_i),
    .rob_sq_i     (rob_squashing_i),
    .stall_i      (stall_i),
    .rob_empty_i  (rob_empty_i),
    .fl_zero_i    (fl_zero),
    .in_valid_i   (in_valid_i),
    .in_seq_i     (in_seq_i),
    .in_ser_i     (in_ser_i),
    .sk_count_i   (sk_count),
    .sk_view_i    (sk_view),
    .state_o      (st),
    .emit_o       (emit),
    .emit_seq_o   (emit_seq),
    .blk_o        (blk),
    .ublk_o       (ublk),
    .push_o       (sk_push),
    .push_ent_o   (sk_ent),
    .pop_cnt_o    (sk_pop),
    .kill_o       (sk_kill)
  );

  assign state_o = st;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_valid_o   <= 1'b0;
      out_seq_o     <= '0;
      dec_block_o   <= 1'b0;
      dec_unblock_o <= 1'b0;
    end else begin
      out_valid_o   <= emit;
      out_seq_o     <= emit_seq;
      dec_block_o   <= blk;
      dec_unblock_o <= ublk;
    end
  end
endmodule

// File: rtl/rn_stall_ctrl_chk.sv
module rn_stall_ctrl_chk
  import rn_pkg::*;
#(
  parameter int unsigned BP_DELAY = 2
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       squash_i,
  input logic       out_valid_o,
  input logic       dec_block_o,
  input logic       dec_unblock_o,
  input logic [2:0] state_o,
  input logic       sk_push,
  input logic [$clog2(2 * BP_DELAY + 2)-1:0] sk_count,
  input logic [$clog2(2 * BP_DELAY + 2)-1:0] sk_pop,
  input logic       fl_zero
);
  localparam int unsigned DEPTH = 2 * BP_DELAY + 1;

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(sk_push && (int'(sk_count) - int'(sk_pop) >= int'(DEPTH))));

  // R2
  squash_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    squash_i |=> (state_o == ST_SQ));

  // R3
  block_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(dec_block_o && dec_unblock_o));

  // R3
  block_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    dec_block_o |-> (state_o == ST_BLK || state_o == ST_SER));

  // R5
  unblock_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    dec_unblock_o |-> (state_o == ST_RUN || state_o == ST_SQ));

  // R8
  ser_no_emit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    out_valid_o |-> (state_o != ST_SER));

  // R9
  ser_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == ST_SER && !fl_zero) |=> !out_valid_o);
endmodule

bind rn_stall_ctrl rn_stall_ctrl_chk #(.BP_DELAY(BP_DELAY)) chk_i (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .squash_i      (squash_i),
  .out_valid_o   (out_valid_o),
  .dec_block_o   (dec_block_o),
  .dec_unblock_o (dec_unblock_o),
  .state_o       (state_o),
  .sk_push       (sk_push),
  .sk_count      (sk_count),
  .sk_pop        (sk_pop),
  .fl_zero       (fl_zero)
);

// File: tb/rn_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module rn_stall_ctrl_tb_top;
  localparam int BP_DELAY = 2;
  localparam int DEPTH    = 2 * BP_DELAY + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 0, in_ser = 0, squash = 0, rob_sq = 0;
  logic        stall = 0, rob_empty = 0, dispatch = 0;
  logic [15:0] in_seq = 0, squash_seq = 0;
  logic        out_valid, dec_block, dec_unblock;
  logic [15:0] out_seq;
  logic [2:0]  state;

  always #4 clk = ~clk;

  rn_stall_ctrl #(.BP_DELAY(BP_DELAY)) dut_i (
    .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_seq_i(in_seq),
    .in_ser_i(in_ser), .out_valid_o(out_valid), .out_seq_o(out_seq),
    .squash_i(squash), .squash_seq_i(squash_seq), .rob_squashing_i(rob_sq),
    .stall_i(stall), .rob_empty_i(rob_empty), .dispatch_i(dispatch),
    .dec_block_o(dec_block), .dec_unblock_o(dec_unblock), .state_o(state)
  );

  typedef struct { int seq; bit ser; bit dead; } ent_t;
  ent_t q[$];
  int m_state = 0, held = 0, infl = 0, nseq = 1;
  bit e_ov = 0, e_blk = 0, e_ublk = 0;
  int e_oseq = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic ent_t mk();
    ent_t e; e.seq = in_seq; e.ser = in_ser; e.dead = 0; return e;
  endfunction

  // expected next outputs from the requirements
  task automatic model_step();
    int ns = m_state; bit drain = 0, run = 0;
    e_ov = 0; e_blk = 0; e_ublk = 0;
    if (squash) begin
      if (m_state == 2 || m_state == 3 || m_state == 5) e_ublk = 1;
      foreach (q[k]) if (q[k].seq > int'(squash_seq)) q[k].dead = 1;
      if (in_valid && !(in_seq > squash_seq)) q.push_back(mk());
      ns = 4;
    end else if (rob_sq) begin
      if (in_valid) q.push_back(mk());
      ns = 4;
    end else if (stall) begin
      if (m_state != 2 && m_state != 3) e_blk = 1;
      if (m_state != 5) ns = 2;
      if (in_valid) q.push_back(mk());
    end else begin
      case (m_state)
        5: if (rob_empty && infl == 0) begin
             e_ov = 1; e_oseq = held;
             if (q.size() != 0) begin ns = 3; if (in_valid) q.push_back(mk()); end
             else if (in_valid) begin q.push_back(mk()); e_blk = 1; ns = 2; end
             else ns = 1;
           end else if (in_valid) q.push_back(mk());
        2, 3: drain = 1;
        4: if (q.size() != 0) drain = 1; else begin run = 1; ns = 1; end
        default: run = 1;
      endcase
    end
    if (drain) begin
      bit stop = 0;
      while (q.size() > 0 && !stop) begin
        ent_t e = q.pop_front();
        if (!e.dead) begin
          stop = 1;
          if (e.ser) begin ns = 5; held = e.seq; end
          else begin e_ov = 1; e_oseq = e.seq; end
        end
      end
      if (in_valid) q.push_back(mk());
      if (ns != 5) begin
        if (q.size() == 0) begin e_ublk = 1; ns = 1; end else ns = 3;
      end
    end
    if (run && in_valid) begin
      if (in_ser) begin ns = 5; held = in_seq; e_blk = 1; end
      else begin e_ov = 1; e_oseq = in_seq; ns = 1; end
    end
    if (e_ov && !dispatch) infl++;
    else if (!e_ov && dispatch && infl > 0) infl--;
    m_state = ns;
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(state == 3'(m_state), tag, "state", state, m_state);
    chk(out_valid == e_ov, tag, "out_valid", out_valid, e_ov);
    if (e_ov) chk(out_seq == 16'(e_oseq), tag, "out_seq", out_seq, e_oseq);
    chk(dec_block == e_blk, tag, "block", dec_block, e_blk);
    chk(dec_unblock == e_ublk, tag, "unblock", dec_unblock, e_ublk);
  endtask

  task automatic clr();
    in_valid = 0; in_ser = 0; squash = 0; rob_sq = 0;
    stall = 0; rob_empty = 0; dispatch = 0;
  endtask

  task automatic arrive(bit ser);
    in_valid = 1; in_ser = ser; in_seq = 16'(nseq); nseq++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(state == 3'd0, "R1", "state", state, 0);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(dec_block == 0 && dec_unblock == 0, "R1", "block/unblock",
        int'(dec_block) + int'(dec_unblock), 0);
    rst = 0;

    clr(); arrive(0); tick("R11");
    clr(); stall = 1; arrive(0); tick("R3");
    arrive(0); tick("R3");
    clr(); tick("R4");
    tick("R5");
    clr(); stall = 1;
    for (int i = 0; i < 3; i++) begin arrive(0); tick("R7"); end
    clr(); squash = 1; squash_seq = 16'(nseq - 3); tick("R6");
    clr(); stall = 1; arrive(0); tick("R7");
    clr(); tick("R7");
    tick("R7");
    clr(); squash = 1; squash_seq = 16'(nseq - 1); stall = 1; tick("R2");
    clr(); rob_sq = 1; stall = 1; tick("R2");
    clr(); tick("R4");
    clr(); arrive(1); tick("R8");
    clr(); arrive(0); tick("R8");
    clr(); rob_empty = 1; tick("R9");
    while (infl > 0) begin clr(); dispatch = 1; tick("R9"); end
    clr(); rob_empty = 1; tick("R8");
    clr(); tick("R8");
    clr(); arrive(1); tick("R12");
    while (infl > 0) begin clr(); dispatch = 1; tick("R12"); end
    clr(); rob_empty = 1; arrive(0); tick("R12");
    clr(); tick("R12");
    clr(); arrive(1); tick("R6");
    clr(); squash = 1; squash_seq = 16'(nseq - 2); tick("R6");
    clr(); tick("R6");
    clr(); stall = 1;
    for (int i = 0; i < DEPTH; i++) begin arrive(0); tick("R10"); end
    clr();
    for (int i = 0; i < DEPTH; i++) tick("R10");

    for (int c = 0; c < 3000; c++) begin
      clr();
      if (q.size() < DEPTH && ($urandom % 100) < 60) arrive(($urandom % 100) < 10);
      squash = ($urandom % 100) < 3;
      squash_seq = 16'((nseq > 6) ? nseq - 1 - int'($urandom % 6) : 0);
      rob_sq = ($urandom % 100) < 4;
      stall = ($urandom % 100) < 25;
      rob_empty = ($urandom % 100) < 40;
      dispatch = (infl > 0) && ((($urandom % 100) < 60) || infl >= 40);
      tick("R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule